// File: doc/BRIEF.md
# Carry-in Compressed Population Counter

This block reports how many bits are set in a 31-bit data word as a 5-bit count in the range 0 to 31. The count comes from a fixed adder tree of four stages. Eight three-input full adders reduce 24 of the bits to 2-bit partial counts. Each later stage adds pairs of partial sums. At each of those later stages, one of the remaining raw input bits goes in as the carry-in of the adder. This means every adder input is used, and the tree covers exactly 31 bits with no stray correction logic.

Data moves on a valid/ready stream. A word is accepted on a clock edge where `in_valid` and `in_ready` are both high. A count is consumed on an edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the output holds its count and its valid flag.

The parameter `REG_OUT` selects one of two builds:
- Registered build (the default): adds one output register with a synchronous, active-high reset. This stage takes a new word whenever it is empty or being drained in the same cycle.
- Combinational build: the stream passes straight through. `out_valid` follows `in_valid`, and `in_ready` follows `out_ready`, in the same cycle.

Input bit mapping:
- Bits 0 to 23 feed the first-stage full adders, three bits each: adder i takes bits 3i to 3i+2.
- Bits 24 to 27 are the carry-ins of the four second-stage adders.
- Bits 28 and 29 are the carry-ins of the two third-stage adders.
- Bit 30 is the carry-in of the final adder.

Top module: `popcnt31`

## Requirements
- R1: When `out_valid` is high, `out_count` equals the number of bits set in the accepted 31-bit `in_data` word.
- R2: An all-zero word gives a count of 0, and an all-one word (0x7FFFFFFF) gives a count of 31.
- R3: Every bit position, including the seven carry-in bits 24 to 30, adds exactly one to the count. A word with a single one gives 1, and a word with a single zero gives 30.
- R4: With `REG_OUT` = 0, `out_count` and `out_valid` follow `in_data` and `in_valid` in the same cycle, and `in_ready` equals `out_ready`.
- R5: With `REG_OUT` = 1, a word accepted on a clock edge shows up with `out_valid` high and its count right after that edge, a latency of one cycle.
- R6: With `REG_OUT` = 1, while `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_count` keeps its value, whatever the input does.
- R7: With `REG_OUT` = 1, `in_ready` is high whenever the output register is empty or `out_ready` is high. It is low only while a held count is stalled.
- R8: With `REG_OUT` = 1, `rst` high on a clock edge clears `out_valid` to 0 and `out_count` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word is present |
| in_ready | output | 1 | Block can take an input word |
| in_data | input | 31 | Word whose set bits are counted |
| out_valid | output | 1 | Count is present |
| out_ready | input | 1 | Downstream takes the count |
| out_count | output | 5 | Number of set bits, 0 to 31 |

## Verification
Three kinds of internal fault show up as count errors:
- A swapped or dropped tree connection, or a broken carry inside an adder, gives a count that is off by a power of two.
- If a carry-in bit is lost, only the words that set that bit are miscounted. Walking-one and walking-zero words expose each such bit on its own.
- Every adder is combinational, so a tree fault is visible in the same cycle in the pass-through build and on the first output cycle after the word is accepted in the registered build.

Faults in the output stage show up in the stream signals:
- A corrupted valid or hold register either drops a count or changes a stalled count. This is visible one edge after the stall begins.

// File: rtl/popcnt_pkg.sv
package popcnt_pkg;
  localparam int DATA_W   = 31;
  localparam int CNT_W    = 5;
  localparam int FA_IN    = 3;
  localparam int N_FA     = 8;
  localparam int FA_SPAN  = N_FA * FA_IN;    // bits counted by full adders
  localparam int N_S2     = N_FA / 2;        // second-stage merges
  localparam int N_S3     = N_S2 / 2;        // third-stage merges
  localparam int S1_W     = 2;
  localparam int S2_W     = S1_W + 1;
  localparam int S3_W     = S2_W + 1;
  localparam int CI_S2    = FA_SPAN;         // first carry-in bit, stage 2
  localparam int CI_S3    = CI_S2 + N_S2;    // first carry-in bit, stage 3
  localparam int CI_S4    = CI_S3 + N_S3;    // carry-in bit, final stage
endpackage

// File: rtl/pc_fa3.sv
module pc_fa3 (
  input  logic [2:0] bits,
  output logic [1:0] cnt
);
  always_comb begin
    cnt[0] = bits[0] ^ bits[1] ^ bits[2];
    cnt[1] = (bits[0] & bits[1]) | (bits[0] & bits[2]) | (bits[1] & bits[2]);
  end
endmodule

// File: rtl/pc_merge.sv
// Ripple adder of two W-bit partial counts plus one raw bit as carry-in.
module pc_merge #(
  parameter int W = 2
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W:0]   sum
);
  logic [W:0]   carry;
  logic [W-1:0] s;

  assign carry[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign s[i]       = a[i] ^ b[i] ^ carry[i];
    assign carry[i+1] = (a[i] & b[i]) | (a[i] & carry[i]) | (b[i] & carry[i]);
  end

  assign sum = {carry[W], s};
endmodule

// File: rtl/pc_out_stage.sv
module pc_out_stage #(
  parameter int W       = 5,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] cnt_d,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_count
);
  if (REG_OUT) begin : g_reg
    logic         vld_q;
    logic [W-1:0] cnt_q;

    assign in_ready = !vld_q || out_ready;

    always_ff @(posedge clk) begin
      if (rst) begin
        vld_q <= 1'b0;
        cnt_q <= '0;
      end else if (in_ready) begin
        vld_q <= in_valid;
        if (in_valid) cnt_q <= cnt_d;
      end
    end

    assign out_valid = vld_q;
    assign out_count = cnt_q;
  end else begin : g_comb
    logic unused_clkrst;
    assign unused_clkrst = clk ^ rst;
    assign in_ready  = out_ready;
    assign out_valid = in_valid;
    assign out_count = cnt_d;
  end
endmodule

// File: rtl/popcnt31.sv
module popcnt31 #(
  parameter bit REG_OUT = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [30:0] in_data,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [4:0]  out_count
);
  import popcnt_pkg::*;

  logic [S1_W-1:0]  s1 [N_FA];
  logic [S2_W-1:0]  s2 [N_S2];
  logic [S3_W-1:0]  s3 [N_S3];
  logic [CNT_W-1:0] total;

  // Stage 1: three raw bits per full adder.
  for (genvar i = 0; i < N_FA; i++) begin : g_s1
    pc_fa3 u_fa (
      .bits (in_data[FA_IN*i +: FA_IN]),
      .cnt  (s1[i])
    );
  end

  // Stage 2: pairs of 2-bit counts, raw bit as carry-in.
  for (genvar j = 0; j < N_S2; j++) begin : g_s2
    pc_merge #(.W(S1_W)) u_add (
      .a   (s1[2*j]),
      .b   (s1[2*j+1]),
      .cin (in_data[CI_S2 + j]),
      .sum (s2[j])
    );
  end

  // Stage 3: pairs of 3-bit counts, raw bit as carry-in.
  for (genvar k = 0; k < N_S3; k++) begin : g_s3
    pc_merge #(.W(S2_W)) u_add (
      .a   (s2[2*k]),
      .b   (s2[2*k+1]),
      .cin (in_data[CI_S3 + k]),
      .sum (s3[k])
    );
  end

  // Stage 4: final merge, last raw bit as carry-in.
  pc_merge #(.W(S3_W)) u_final (
    .a   (s3[0]),
    .b   (s3[1]),
    .cin (in_data[CI_S4]),
    .sum (total)
  );

  pc_out_stage #(.W(CNT_W), .REG_OUT(REG_OUT)) u_out (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .cnt_d     (total),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_count (out_count)
  );
endmodule

// File: rtl/popcnt31_chk.sv
module popcnt31_chk #(
  parameter bit REG_OUT = 1'b1
) (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic        in_ready,
  input logic [30:0] in_data,
  input logic        out_valid,
  input logic        out_ready,
  input logic [4:0]  out_count
);
  logic [4:0] exp_q;

  always_ff @(posedge clk) begin
    if (rst) exp_q <= '0;
    else if (in_valid && in_ready) exp_q <= 5'($countones(in_data));
  end

  if (REG_OUT) begin : g_reg
    p_count_r1: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> out_count == exp_q);
    p_latency_r5: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_ready) |=> out_valid);
    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_count)));
    p_ready_r7: assert property (@(posedge clk) disable iff (rst)
      !out_valid |-> in_ready);
    p_clear_r8: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!out_valid && out_count == 5'd0));
  end else begin : g_comb
    p_count_r1: assert property (@(posedge clk) disable iff (rst)
      in_valid |-> out_count == 5'($countones(in_data)));
    p_extremes_r2: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_data == 31'h7FFF_FFFF) |-> out_count == 5'd31);
    p_pass_r4: assert property (@(posedge clk) disable iff (rst)
      (out_valid == in_valid) && (in_ready == out_ready));
    p_shadow_r1: assert property (@(posedge clk) disable iff (rst)
      $past(in_valid && in_ready) |-> exp_q == $past(out_count));
  end
endmodule

bind popcnt31 popcnt31_chk #(.REG_OUT(REG_OUT)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_count (out_count)
);

// File: tb/tb_popcnt31.sv
`timescale 1ns/1ps
module tb_popcnt31;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [30:0] in_data = '0;
  logic        out_ready = 1'b1;
  logic        in_ready, out_valid;
  logic [4:0]  out_count;
  logic        c_in_ready, c_out_valid;
  logic [4:0]  c_out_count;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;   // 125 MHz

  popcnt31 #(.REG_OUT(1'b1)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_count(out_count));

  popcnt31 #(.REG_OUT(1'b0)) dut_comb (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(c_in_ready),
    .in_data(in_data), .out_valid(c_out_valid), .out_ready(out_ready),
    .out_count(c_out_count));

  // {data, expected count}
  localparam int NV = 13;
  localparam logic [35:0] VEC [NV] = '{
    {31'h0000_0000, 5'd0},  {31'h7FFF_FFFF, 5'd31}, {31'h0000_0001, 5'd1},
    {31'h4000_0000, 5'd1},  {31'h5555_5555, 5'd16}, {31'h2AAA_AAAA, 5'd15},
    {31'h0000_FFFF, 5'd16}, {31'h7FFF_0000, 5'd15}, {31'h1234_5678, 5'd13},
    {31'h0F0F_0F0F, 5'd16}, {31'h7F80_0000, 5'd8},  {31'h00FF_FFFF, 5'd24},
    {31'h7F00_0000, 5'd7}
  };

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int ref_count(logic [30:0] d);
    int n = 0;
    for (int b = 0; b < 31; b++) n += int'(d[b]);
    return n;
  endfunction

  // Drive one word with out_ready high; check pass-through build, then the
  // registered build one edge later.
  task automatic send(logic [30:0] d, int exp, string req);
    @(negedge clk);
    in_data = d; in_valid = 1'b1; out_ready = 1'b1;
    #1;
    chk({req, " comb count (R4)"}, int'(c_out_count), exp);
    @(posedge clk);
    @(negedge clk);
    chk({req, " reg valid (R5)"}, int'(out_valid), 1);
    chk({req, " reg count (R5)"}, int'(out_count), exp);
    in_valid = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected <= 100000 cycles", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [30:0] rv;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R8 reset valid", int'(out_valid), 0);
    chk("R8 reset count", int'(out_count), 0);
    chk("R7 ready after reset", int'(in_ready), 1);
    rst = 1'b0;

    // R1 R2 table walk
    for (int i = 0; i < NV; i++)
      send(VEC[i][35:5], int'(VEC[i][4:0]), "R1/R2 table");

    // R4 pass-through handshake
    @(negedge clk);
    in_valid = 1'b1; out_ready = 1'b0; #1;
    chk("R4 comb valid", int'(c_out_valid), 1);
    chk("R4 comb ready", int'(c_in_ready), 0);
    in_valid = 1'b0; out_ready = 1'b1; #1;
    chk("R4 comb valid low", int'(c_out_valid), 0);
    chk("R4 comb ready high", int'(c_in_ready), 1);

    // R3 walking one and walking zero
    for (int b = 0; b < 31; b++) begin
      send(31'(1) << b, 1, "R3 walk1");
      send(~(31'(1) << b), 30, "R3 walk0");
    end

    // R1 random words against reference count
    for (int i = 0; i < 200; i++) begin
      rv = 31'($urandom);
      send(rv, ref_count(rv), "R1 random");
    end

    // R6 R7 stall and hold
    @(negedge clk);
    in_data = 31'h0000_00FF; in_valid = 1'b1; out_ready = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R5 stall load valid", int'(out_valid), 1);
    chk("R5 stall load count", int'(out_count), 8);
    chk("R7 ready low in stall", int'(in_ready), 0);
    in_data = 31'h7FFF_FFFF;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R6 held valid", int'(out_valid), 1);
    chk("R6 held count", int'(out_count), 8);
    out_ready = 1'b1; #1;
    chk("R7 ready when draining", int'(in_ready), 1);
    @(posedge clk); @(negedge clk);
    chk("R6 next count after drain", int'(out_count), 31);
    in_valid = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R5 empty after drain", int'(out_valid), 0);
    chk("R7 ready when empty", int'(in_ready), 1);

    // R8 reset while holding a count
    in_data = 31'h0000_0007; in_valid = 1'b1; out_ready = 1'b0;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0; rst = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R8 clear valid", int'(out_valid), 0);
    chk("R8 clear count", int'(out_count), 0);
    rst = 1'b0; out_ready = 1'b1;
    send(31'h0000_0007, 3, "R8 after reset");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule